// File: doc/BRIEF.md
# Accumulator Nibble Rotate Unit

This unit carries out the two decimal-digit rotate operations of an 8-bit accumulator machine. Each operation rotates a 12-bit quantity, four bits at a time. The 12 bits are the low nibble of the accumulator and both nibbles of one memory byte. The memory byte sits at the address held in a 16-bit pointer. The unit reads that byte, writes the rearranged byte back to the same address, and returns a new accumulator and a new flag byte.

A sequencer issues a one-cycle `start` together with the direction, the accumulator, the current carry and the pointer. All of these are captured on the accepting edge. The unit then runs a fixed four-state sequence: idle, read, write, done. The read strobe is raised in the cycle after acceptance. The memory returns its data one cycle later, and in that same cycle the new byte is written back. A one-cycle `done` pulse follows, and `acc_out` and `flag_out` stay valid after it until the next operation completes.

Top module: `nib_rot_unit`

## Requirements
- R1: After reset, `done`, `mem_rd_en` and `mem_wr_en` are 0, and `acc_out` and `flag_out` are 0x00.
- R2: With `dir_right` = 0 (rotate left), the byte written back is the old memory byte's low nibble in bits 7:4 and the accumulator's low nibble in bits 3:0.
- R3: With `dir_right` = 0, `acc_out` keeps the accumulator's high nibble and takes the old memory byte's high nibble as its low nibble.
- R4: With `dir_right` = 1 (rotate right), the byte written back is the accumulator's low nibble in bits 7:4 and the old memory byte's high nibble in bits 3:0.
- R5: With `dir_right` = 1, `acc_out` keeps the accumulator's high nibble and takes the old memory byte's low nibble as its low nibble.
- R6: `flag_out` bit 7 equals `acc_out` bit 7, bit 6 is 1 exactly when `acc_out` is zero, bit 5 equals `acc_out` bit 5, and bit 3 equals `acc_out` bit 3.
- R7: `flag_out` bit 2 is 1 exactly when `acc_out` has an even number of one bits.
- R8: `flag_out` bits 4 and 1 are 0, and `flag_out` bit 0 equals the `carry_in` captured at start.
- R9: Timing of one operation, where the start is accepted at edge k:
  - `mem_rd_en` is high, with `mem_addr` equal to the pointer, for the cycle after edge k.
  - `mem_wr_en` is high, with the same address, for the cycle after that.
  - The read and write strobes are never high together.
- R10: `done` is high for exactly the one cycle after the write cycle, and `acc_out` and `flag_out` are valid from that cycle on.
- R11: A `start` that arrives while an operation is in progress is ignored: no second read or write follows, and the results are those of the accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dir_right | input | 1 | 0 = rotate left, 1 = rotate right |
| acc_in | input | 8 | Accumulator value |
| carry_in | input | 1 | Current carry flag |
| ptr_in | input | ADDR_W (16) | Memory address of the operand byte |
| mem_addr | output | ADDR_W (16) | Memory address for read and write |
| mem_rd_en | output | 1 | Read strobe; data is returned on the following cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte written back |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| acc_out | output | 8 | New accumulator |
| flag_out | output | 8 | New flag byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume a memory whose read data is valid exactly one cycle after the read strobe. The write phase consumes `mem_rdata` without any wait state. The bench's memory model has exactly that latency, and it updates its contents on the write strobe. The properties place no requirement on how `start` is timed. To exercise the ignored-start path, the bench raises `start` again, with a different direction and accumulator, during the read and write cycles of a running operation.

// File: rtl/nib_rot_pkg.sv
package nib_rot_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;

  // flag byte bit positions
  localparam int FL_SIGN = 7;
  localparam int FL_ZERO = 6;
  localparam int FL_CPY5 = 5;
  localparam int FL_HALF = 4;
  localparam int FL_CPY3 = 3;
  localparam int FL_PAR  = 2;
  localparam int FL_SUB  = 1;
  localparam int FL_CARY = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } nr_state_e;

  // byte to store back into memory
  function automatic logic [DATA_W-1:0] nr_mem_byte(
    input logic              go_right,
    input logic [DATA_W-1:0] acc,
    input logic [DATA_W-1:0] mem
  );
    logic [DATA_W-1:0] r;
    if (go_right)
      r = {acc[NIB_W-1:0], mem[DATA_W-1:NIB_W]};
    else
      r = {mem[NIB_W-1:0], acc[NIB_W-1:0]};
    return r;
  endfunction

  // new accumulator: high nibble kept, low nibble from memory
  function automatic logic [DATA_W-1:0] nr_acc_byte(
    input logic              go_right,
    input logic [DATA_W-1:0] acc,
    input logic [DATA_W-1:0] mem
  );
    logic [NIB_W-1:0] lo;
    lo = go_right ? mem[NIB_W-1:0] : mem[DATA_W-1:NIB_W];
    return {acc[DATA_W-1:NIB_W], lo};
  endfunction

  // flag byte derived from new accumulator, carry passed through
  function automatic logic [DATA_W-1:0] nr_flags(
    input logic [DATA_W-1:0] acc,
    input logic              cy
  );
    logic [DATA_W-1:0] f;
    f          = '0;
    f[FL_SIGN] = acc[DATA_W-1];
    f[FL_ZERO] = (acc == '0);
    f[FL_CPY5] = acc[5];
    f[FL_HALF] = 1'b0;
    f[FL_CPY3] = acc[3];
    f[FL_PAR]  = ~(^acc);
    f[FL_SUB]  = 1'b0;
    f[FL_CARY] = cy;
    return f;
  endfunction

endpackage

// File: rtl/nib_rot_ctrl.sv
module nib_rot_ctrl
  import nib_rot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic rd_phase,
  output logic wr_phase,
  output logic done_phase
);

  nr_state_e state_q, state_d;

  assign accept     = start && (state_q == ST_IDLE);
  assign rd_phase   = (state_q == ST_READ);
  assign wr_phase   = (state_q == ST_WRITE);
  assign done_phase = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9: read phase follows acceptance, write follows read
  a_r9_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_phase);
  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |=> wr_phase);
  // R10: done follows write and lasts one cycle
  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> done_phase);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_phase |=> !done_phase);

endmodule

// File: rtl/nib_rot_datapath.sv
module nib_rot_datapath
  import nib_rot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr_phase,
  input  logic              dir_right,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              carry_in,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] acc_res,
  output logic [DATA_W-1:0] flag_res
);

  logic              dir_q;
  logic [DATA_W-1:0] acc_q;
  logic              cy_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] acc_res_q, flag_res_q;
  logic [DATA_W-1:0] acc_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      acc_q <= '0;
      cy_q  <= 1'b0;
      ptr_q <= '0;
    end else if (accept) begin
      dir_q <= dir_right;
      acc_q <= acc_in;
      cy_q  <= carry_in;
      ptr_q <= ptr_in;
    end
  end

  assign acc_new = nr_acc_byte(dir_q, acc_q, mem_rdata);
  assign wdata   = nr_mem_byte(dir_q, acc_q, mem_rdata);
  assign addr    = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_res_q  <= '0;
      flag_res_q <= '0;
    end else if (wr_phase) begin
      acc_res_q  <= acc_new;
      flag_res_q <= nr_flags(acc_new, cy_q);
    end
  end

  assign acc_res  = acc_res_q;
  assign flag_res = flag_res_q;

  // R3 / R5: accumulator high nibble survives the operation
  a_r3_acc_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> acc_res_q[DATA_W-1:NIB_W] == $past(acc_q[DATA_W-1:NIB_W]));
  // R8: carry passes through, half-carry and subtract cleared
  a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> flag_res_q[FL_CARY] == $past(cy_q));
  a_r8_hn_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> !flag_res_q[FL_HALF] && !flag_res_q[FL_SUB]);
  // R9: pointer stays put across the read-modify-write
  a_r9_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |-> $stable(ptr_q));

endmodule

// File: rtl/nib_rot_unit.sv
module nib_rot_unit
  import nib_rot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_right,
  input  logic [7:0]        acc_in,
  input  logic              carry_in,
  input  logic [ADDR_W-1:0] ptr_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        acc_out,
  output logic [7:0]        flag_out,
  output logic              done
);

  logic accept, rd_phase, wr_phase, done_phase;

  nib_rot_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .accept     (accept),
    .rd_phase   (rd_phase),
    .wr_phase   (wr_phase),
    .done_phase (done_phase)
  );

  nib_rot_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .wr_phase  (wr_phase),
    .dir_right (dir_right),
    .acc_in    (acc_in),
    .carry_in  (carry_in),
    .ptr_in    (ptr_in),
    .mem_rdata (mem_rdata),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .acc_res   (acc_out),
    .flag_res  (flag_out)
  );

  assign mem_rd_en = rd_phase;
  assign mem_wr_en = wr_phase;
  assign done      = done_phase;

  // R9: strobes exclusive, write hits the address just read
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  a_r9_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en) && (mem_addr == $past(mem_addr)));
  // R11: one read per operation, no restart while busy
  a_r11_no_reread: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_wr_en && !done);
  // R6: zero flag agrees with the result once done
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flag_out[FL_ZERO] == (acc_out == 8'h00));

endmodule

// File: tb/nib_rot_unit_tb_top.sv
`timescale 1ns/1ps
module nib_rot_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_right = 1'b0;
  logic [7:0]  acc_in = '0;
  logic        carry_in = 1'b0;
  logic [15:0] ptr_in = '0;
  logic [15:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  acc_out, flag_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem [0:255];

  always #2 clk = ~clk;

  nib_rot_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_right(dir_right),
    .acc_in(acc_in), .carry_in(carry_in), .ptr_in(ptr_in),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc_out(acc_out), .flag_out(flag_out), .done(done)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ex_wbyte(logic r, logic [7:0] a, logic [7:0] m);
    return r ? {a[3:0], m[7:4]} : {m[3:0], a[3:0]};
  endfunction

  function automatic logic [7:0] ex_acc(logic r, logic [7:0] a, logic [7:0] m);
    logic [7:0] x;
    x[7:4] = a[7:4];
    x[3:0] = r ? m[3:0] : m[7:4];
    return x;
  endfunction

  function automatic logic [7:0] ex_flags(logic [7:0] a, logic c);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += a[i];
    return {a[7], (a == 8'h00), a[5], 1'b0, a[3], (ones % 2 == 0), 1'b0, c};
  endfunction

  task automatic run_op(input logic r, input logic [7:0] a, input logic c,
                        input logic [15:0] p, input logic [7:0] m, input bit poke);
    logic [7:0] ea, ef, ew;
    string rw, ra;
    ew = ex_wbyte(r, a, m);
    ea = ex_acc(r, a, m);
    ef = ex_flags(ea, c);
    rw = r ? "R4" : "R2";
    ra = r ? "R5" : "R3";
    mem[p[7:0]] = m;
    start = 1'b1; dir_right = r; acc_in = a; carry_in = c; ptr_in = p;
    @(negedge clk);
    if (poke) begin
      start = 1'b1; dir_right = ~r; acc_in = ~a; carry_in = ~c; ptr_in = ~p;
    end else start = 1'b0;
    chk("R9 read strobe", mem_rd_en, 1);
    chk("R9 read addr", mem_addr, p);
    chk("R9 no write in read", mem_wr_en, 0);
    @(negedge clk);
    chk("R9 write strobe", mem_wr_en, 1);
    chk("R9 write addr", mem_addr, p);
    chk("R9 no read in write", mem_rd_en, 0);
    chk(rw, mem_wdata, ew);
    start = 1'b0;
    @(negedge clk);
    chk("R10 done", done, 1);
    chk(ra, acc_out, ea);
    chk("R6 sign/zero/copies", {flag_out[7:5], flag_out[3]}, {ef[7:5], ef[3]});
    chk("R7 parity", flag_out[2], ef[2]);
    chk("R8 half/sub/carry", {flag_out[4], flag_out[1], flag_out[0]}, {ef[4], ef[1], ef[0]});
    @(negedge clk);
    chk("R10 done single", done, 0);
    chk("R11 no restart", {mem_rd_en, mem_wr_en}, 0);
    chk("R11 memory byte", mem[p[7:0]], ew);
    chk("R11 results held", {acc_out, flag_out}, {ea, ef});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 strobes", {mem_rd_en, mem_wr_en}, 0);
    chk("R1 acc/flags", {acc_out, flag_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {done, mem_rd_en, mem_wr_en}, 0);
    // directed corners
    run_op(1'b0, 8'h00, 1'b0, 16'h0000, 8'h0F, 0); // left, zero result
    run_op(1'b1, 8'h00, 1'b1, 16'hFFFF, 8'hF0, 0); // right, zero result, carry kept
    run_op(1'b0, 8'h12, 1'b1, 16'h1234, 8'h34, 0); // odd parity result
    run_op(1'b1, 8'hA5, 1'b0, 16'h8001, 8'h7C, 0);
    run_op(1'b0, 8'hFF, 1'b1, 16'h00FF, 8'hFF, 0); // all ones
    run_op(1'b1, 8'h3C, 1'b0, 16'h4242, 8'h96, 1); // start while busy
    run_op(1'b0, 8'h81, 1'b1, 16'hC0DE, 8'h5A, 1);
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_op(rv[0], $urandom, rv[1], $urandom, $urandom, rv[2]);
      if (rv[3]) @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule